// File: doc/BRIEF.md
# Line BIP-8 Generator and Checker for a Byte-Serial STS-1 Stream

This block works on the transmit and receive sides of a byte-serial STS-1 line. On transmit it follows the frame position of each incoming byte. It folds every byte outside the section overhead corner into an even bit-interleaved parity. At the next start of frame it freezes that parity and writes it into the B2 slot of the new frame. The bytes it checks are the ones it emits, before any scrambling stage further down. It also writes the most recent remote error count into the low nibble of the M0 slot.

On receive it follows the incoming frame position in the same way and computes the same parity. At the received B2 slot it compares the byte on the line with the parity it computed over the previous received frame. The number of bit positions that differ becomes the 4-bit line remote error indication. That value is held on its own port, and the transmit side also places it in M0.

Frame size and slot positions are parameters. Positions are counted from zero. By default a frame is 9 rows of 90 bytes, B2 sits at row 4 column 0, and M0 sits at row 8 column 2.

Top module: `line_bip8_unit`

## Requirements
- R1: Each byte accepted with `in_valid` high appears on `out_data` exactly one clock later with `out_valid` high. Every byte except those in the B2 and M0 slots appears unchanged. A cycle with `in_valid` low gives `out_valid` low one clock later and does not advance the frame position.
- R2: The byte leaving at frame byte index 360 (row 4, column 0) is the even parity, bit by bit, of all covered output bytes of the previous transmit frame. Covered bytes are all bytes outside the section overhead, including that frame's own B2 and M0 bytes. The first frame after reset carries 0x00.
- R3: Bytes in rows 0 to 2, columns 0 to 2 of a frame have no effect on any parity value.
- R4: Bytes accepted after reset but before the first `in_sof` pass through unchanged. They have no effect on parity.
- R5: A byte with `in_sof` high is frame byte 0 wherever the previous frame had reached. It closes the previous frame's parity even if that frame was cut short.
- R6: The byte leaving at frame byte index 722 (row 8, column 2) keeps input bits 7:4. Bits 3:0 are replaced with the current `rei_l`.
- R7: After the receive byte at index 360 is accepted, `rei_l` equals the number of differing bits between that byte and the parity of the previous received frame. That parity uses the same coverage as R2 and is 0x00 before any frame. `rei_valid` pulses high for exactly one clock, and `rei_l` holds its value until the next receive B2 slot.
- R8: While `rst_n` is low at a clock edge, `out_valid`, `out_data`, `rei_l` and `rei_valid` become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transmit byte present |
| in_sof | input | 1 | Transmit byte is frame byte 0 |
| in_data | input | 8 | Transmit byte before B2/M0 fill |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Transmit byte with B2 and M0 filled |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Receive byte is frame byte 0 |
| rx_data | input | 8 | Receive byte |
| rei_l | output | 4 | Bit errors found in the last received B2 |
| rei_valid | output | 1 | One-clock pulse when `rei_l` is refreshed |

## Verification
The transmit side is driven with several frame patterns:
- An all-zero frame shows that parity starts clean after reset.
- A counting frame tests per-bit-lane parity.
- An all-ones frame with idle gaps shows that gaps neither shift the frame position nor add to the parity.
- A frame that is zero except in the section overhead corner would flip every bit of the next B2 if the exclusion were missing.
- A truncated frame followed by an early start of frame tests that the next B2 carries the parity of the partial frame.

On receive, B2 bytes are corrupted by masks of 0, 1, 5 and 8 bits. This separates a correct bit count from a simple flag or a capped count. The frames run back to back, so each receive comparison also depends on the parity carried over from the previous frame.

// File: rtl/line_bip8_pkg.sv
// Package: shared helpers for the line BIP-8 unit.
// Assumes: callers pass byte-wide values; widths are set by the caller's parameters.
package line_bip8_pkg;

    // Number of ones in an 8-bit value, used when counting mismatched bits.
    function automatic int unsigned ones_in_byte(input logic [7:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/frame_position.sv
// Module: frame_position
// Tracks the row/column of each accepted byte within a fixed-size frame.
// A byte with sof high is always position (0,0). Bytes seen before the first
// sof after reset are reported as outside any frame.
// Assumes: COLS >= 2, ROWS >= 1.
module frame_position #(
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int TOH_COLS = 3,
    parameter int SOH_ROWS = 3,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW      = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          sof,
    output logic          in_frame,
    output logic          covered,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          locked_q;
    logic          soh_hit;

    // Position of the byte presented this cycle.
    always_comb begin
        cur_row  = sof ? '0 : row_q;
        cur_col  = sof ? '0 : col_q;
        in_frame = valid && (sof || locked_q);
        soh_hit  = (int'(cur_row) < SOH_ROWS) && (int'(cur_col) < TOH_COLS);
        covered  = in_frame && !soh_hit;
    end

    // Advance to the position of the next byte after each accepted in-frame byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            col_q    <= '0;
            locked_q <= 1'b0;
        end else if (in_frame) begin
            locked_q <= 1'b1;
            if (int'(cur_col) == COLS - 1) begin
                col_q <= '0;
                row_q <= (int'(cur_row) == ROWS - 1) ? '0 : cur_row + RW'(1);
            end else begin
                col_q <= cur_col + CW'(1);
                row_q <= cur_row;
            end
        end
    end

    // R5: a start-of-frame byte puts the next byte at row 0, column 1.
    a_r5_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sof) |=> (row_q == '0 && col_q == CW'(1)));

    // R1: an idle cycle does not move the frame position.
    a_r1_idle_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(row_q) && $stable(col_q) && $stable(locked_q)));

endmodule

// File: rtl/bip_accumulator.sv
// Module: bip_accumulator
// Folds covered bytes into an even bit-interleaved parity. On frame start it
// freezes the running value as the previous frame's result and restarts.
// Assumes: start and take are qualified by the caller's valid.
module bip_accumulator #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic [W-1:0] held
);

    logic [W-1:0] acc_q;

    // Running XOR per bit lane; snapshot into held on each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            held  <= '0;
        end else if (start) begin
            held  <= acc_q;
            acc_q <= take ? din : '0;
        end else if (take) begin
            acc_q <= acc_q ^ din;
        end
    end

    // R2: the frozen parity only changes on a frame start.
    a_r2_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(held));

    // R3: bytes that are not taken leave the running parity untouched.
    a_r3_skip_untaken: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !take) |=> $stable(acc_q));

endmodule

// File: rtl/rei_counter.sv
// Module: rei_counter
// Compares a received parity byte with the locally computed one and reports the
// number of differing bits, saturated to the REI field width.
// Assumes: strobe is high for exactly one accepted byte per frame.
module rei_counter #(
    parameter int BYTE_W = 8,
    parameter int REI_W  = 4,
    localparam int REI_MAX = (1 << REI_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] expect_byte,
    output logic [REI_W-1:0]  rei_l,
    output logic              rei_valid
);

    int unsigned       mism;
    logic [REI_W-1:0]  rei_next;

    // Count differing bit lanes and clip to the field.
    always_comb begin
        mism = 0;
        for (int i = 0; i < BYTE_W; i++) begin
            mism += int'(rx_byte[i] ^ expect_byte[i]);
        end
        rei_next = (mism > REI_MAX) ? REI_W'(REI_MAX) : REI_W'(mism);
    end

    // Register the count at the B2 slot and pulse the refresh flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rei_l     <= '0;
            rei_valid <= 1'b0;
        end else begin
            rei_valid <= strobe;
            if (strobe) begin
                rei_l <= rei_next;
            end
        end
    end

    // R7: the count never exceeds the number of bit lanes.
    a_r7_rei_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rei_l) <= BYTE_W);

    // R7: the count stays put between refreshes.
    a_r7_rei_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(rei_l) && !rei_valid));

endmodule

// File: rtl/line_bip8_unit.sv
// Module: line_bip8_unit (top)
// Transmit: fills the B2 slot with last frame's line parity and the M0 low
// nibble with the remote error count. Receive: recomputes line parity and
// counts bit errors in the received B2.
// Assumes: byte-serial frames, one byte per valid cycle, slot positions zero-based.
module line_bip8_unit #(
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int TOH_COLS = 3,
    parameter int SOH_ROWS = 3,
    parameter int B2_ROW   = 4,
    parameter int B2_COL   = 0,
    parameter int M0_ROW   = 8,
    parameter int M0_COL   = 2,
    parameter int BYTE_W   = 8,
    parameter int REI_W    = 4,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW      = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [BYTE_W-1:0] rx_data,
    output logic [REI_W-1:0]  rei_l,
    output logic              rei_valid
);

    logic              tx_in_frame, tx_covered, tx_is_b2, tx_is_m0;
    logic [RW-1:0]     tx_row;
    logic [CW-1:0]     tx_col;
    logic [BYTE_W-1:0] tx_held, tx_byte;

    logic              rx_in_frame, rx_covered, rx_is_b2;
    logic [RW-1:0]     rx_row;
    logic [CW-1:0]     rx_col;
    logic [BYTE_W-1:0] rx_held;

    // ---------------- transmit side ----------------
    frame_position #(
        .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS), .SOH_ROWS(SOH_ROWS)
    ) u_tx_pos (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .sof(in_sof),
        .in_frame(tx_in_frame), .covered(tx_covered),
        .cur_row(tx_row), .cur_col(tx_col)
    );

    // Slot decode and byte substitution for the outgoing stream.
    always_comb begin
        tx_is_b2 = tx_in_frame && (int'(tx_row) == B2_ROW) && (int'(tx_col) == B2_COL);
        tx_is_m0 = tx_in_frame && (int'(tx_row) == M0_ROW) && (int'(tx_col) == M0_COL);
        if (tx_is_b2)
            tx_byte = tx_held;
        else if (tx_is_m0)
            tx_byte = {in_data[BYTE_W-1:REI_W], rei_l};
        else
            tx_byte = in_data;
    end

    bip_accumulator #(.W(BYTE_W)) u_tx_bip (
        .clk(clk), .rst_n(rst_n),
        .start(in_valid && in_sof), .take(tx_covered),
        .din(tx_byte), .held(tx_held)
    );

    // One-stage output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_valid ? tx_byte : out_data;
        end
    end

    // ---------------- receive side ----------------
    frame_position #(
        .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS), .SOH_ROWS(SOH_ROWS)
    ) u_rx_pos (
        .clk(clk), .rst_n(rst_n), .valid(rx_valid), .sof(rx_sof),
        .in_frame(rx_in_frame), .covered(rx_covered),
        .cur_row(rx_row), .cur_col(rx_col)
    );

    // Receive B2 slot decode.
    always_comb begin
        rx_is_b2 = rx_in_frame && (int'(rx_row) == B2_ROW) && (int'(rx_col) == B2_COL);
    end

    bip_accumulator #(.W(BYTE_W)) u_rx_bip (
        .clk(clk), .rst_n(rst_n),
        .start(rx_valid && rx_sof), .take(rx_covered),
        .din(rx_data), .held(rx_held)
    );

    rei_counter #(.BYTE_W(BYTE_W), .REI_W(REI_W)) u_rei (
        .clk(clk), .rst_n(rst_n), .strobe(rx_is_b2),
        .rx_byte(rx_data), .expect_byte(rx_held),
        .rei_l(rei_l), .rei_valid(rei_valid)
    );

    // R1: an accepted byte always produces an output byte next cycle.
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no output byte without an input byte.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: the B2 slot carries the frozen parity of the previous frame.
    a_r2_b2_slot: assert property (@(posedge clk) disable iff (!rst_n)
        tx_is_b2 |=> (out_data == $past(tx_held)));

    // R6: the M0 slot keeps the upper bits and carries the error count below.
    a_r6_m0_slot: assert property (@(posedge clk) disable iff (!rst_n)
        tx_is_m0 |=> (out_data[BYTE_W-1:REI_W] == $past(in_data[BYTE_W-1:REI_W])
                      && out_data[REI_W-1:0] == $past(rei_l)));

endmodule

// File: tb/test_line_bip8_unit.sv
module test_line_bip8_unit;

    localparam int FRAME = 810;
    localparam int NCOL  = 90;
    localparam int B2_IX = 360;
    localparam int M0_IX = 722;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0] rx_data = '0;
    logic [3:0] rei_l;
    logic       rei_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_bip8_unit i_line_bip8_unit (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .rei_l(rei_l), .rei_valid(rei_valid)
    );

    // Scoreboard queues: expected byte and the requirement it proves.
    logic [7:0] q_data[$];
    int         q_tag[$];

    // Transmit reference model state.
    bit         m_locked = 1'b0;
    int         m_pos = 0;
    logic [7:0] m_acc = '0, m_held = '0;
    logic [3:0] m_rei = '0;

    // Receive reference model state.
    logic [7:0] r_acc = '0, r_held = '0;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input int pat, input int ix);
        int r, c;
        r = ix / NCOL;
        c = ix % NCOL;
        case (pat)
            0: return 8'h00;
            1: return ix[7:0];
            2: return 8'hFF;
            3: return (r < 3 && c < 3) ? 8'hFF : 8'h00;
            default: return 8'(ix * 7 + 3);
        endcase
    endfunction

    function automatic bit is_soh(input int ix);
        return (ix / NCOL < 3) && (ix % NCOL < 3);
    endfunction

    // Driver: sends transmit bytes and pushes expected output bytes.
    task automatic send_tx(input int pat, input int nbytes, input bit with_sof,
                           input int gap_every, input int b2tag);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d, e;
            int t;
            if (gap_every > 0 && i > 0 && (i % gap_every) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
                @(negedge clk);
                check(out_valid == 1'b0, "R1", out_valid, 0);
            end else begin
                @(negedge clk);
            end
            d = pat_byte(pat, i);
            if (with_sof && i == 0) begin
                m_locked = 1'b1;
                m_pos    = 0;
                m_held   = m_acc;
                m_acc    = '0;
            end
            e = d;
            t = m_locked ? 1 : 4;
            if (m_locked && m_pos == B2_IX) begin
                e = m_held;
                t = b2tag;
            end else if (m_locked && m_pos == M0_IX) begin
                e = {d[7:4], m_rei};
                t = 6;
            end
            if (m_locked && !is_soh(m_pos)) m_acc = m_acc ^ e;
            if (m_locked) m_pos = (m_pos + 1) % FRAME;
            q_data.push_back(e);
            q_tag.push_back(t);
            in_valid = 1'b1;
            in_sof   = with_sof && (i == 0);
            in_data  = d;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    // Driver: sends one receive frame with a corrupted B2 and checks the count.
    task automatic send_rx(input int pat, input logic [7:0] mask, input logic [3:0] prev_rei);
        bit pending = 1'b0;
        int exp_rei = $countones(mask);
        for (int i = 0; i < FRAME; i++) begin
            logic [7:0] d;
            @(negedge clk);
            if (pending) begin
                check(rei_valid == 1'b1, "R7", rei_valid, 1);
                check(rei_l == 4'(exp_rei), "R7", rei_l, exp_rei);
                pending = 1'b0;
            end else if (i == B2_IX + 2) begin
                check(rei_valid == 1'b0, "R7", rei_valid, 0);
            end
            if (i == 0) begin
                check(rei_l == prev_rei, "R7", rei_l, prev_rei);
                r_held = r_acc;
                r_acc  = '0;
            end
            d = pat_byte(pat, i);
            if (i == B2_IX) begin
                d = r_held ^ mask;
                pending = 1'b1;
            end
            if (!is_soh(i)) r_acc = r_acc ^ d;
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_data  = d;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        m_rei    = 4'(exp_rei);
    endtask

    // Monitor: pops expected bytes as the design emits them.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R1", out_data, 0);
                end else begin
                    logic [7:0] e;
                    int t;
                    e = q_data.pop_front();
                    t = q_tag.pop_front();
                    check(out_data == e, tag_name(t), out_data, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R8: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", out_valid, 0);
        check(out_data == 8'h00, "R8", out_data, 0);
        check(rei_l == 4'h0, "R8", rei_l, 0);
        check(rei_valid == 1'b0, "R8", rei_valid, 0);
        rst_n = 1'b1;

        // R7: receive frames with masks of 0, 1, 8 and 5 wrong bits.
        send_rx(4, 8'h00, 4'd0);
        send_rx(1, 8'h01, 4'd0);
        send_rx(2, 8'hFF, 4'd1);
        send_rx(4, 8'h1F, 4'd8);
        repeat (2) @(negedge clk);
        check(rei_l == 4'd5, "R7", rei_l, 5);

        // R4: stray bytes before the first start of frame.
        send_tx(4, 5, 1'b0, 0, 4);
        // R2: first frame carries 0x00, later frames carry prior parity.
        send_tx(0, FRAME, 1'b1, 0, 2);
        send_tx(1, FRAME, 1'b1, 0, 2);
        // R1: all-ones frame with idle gaps.
        send_tx(2, FRAME, 1'b1, 7, 2);
        // R3: only section overhead bytes are nonzero.
        send_tx(3, FRAME, 1'b1, 0, 2);
        send_tx(0, FRAME, 1'b1, 0, 3);
        // R5: truncated frame closed early by a start of frame.
        send_tx(4, 400, 1'b1, 0, 2);
        send_tx(1, FRAME, 1'b1, 0, 5);
        send_tx(0, B2_IX + 4, 1'b1, 0, 2);
        repeat (4) @(negedge clk);
        check(q_data.size() == 0, "R1", q_data.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule